// File: doc/BRIEF.md
# USB Token Packet Transmitter

This block turns a token request into a serial packet on a differential pair. The request gives a 4-bit packet type, a 7-bit device address and a 4-bit endpoint number, and a one-cycle `start` pulse launches it. The block first sends a synchronisation byte. It then sends the packet-identifier byte, which carries the type together with its complement as a check nibble. The address and endpoint fields follow, and the packet closes with a 5-bit CRC computed over those two fields.

Line coding is NRZI. A zero is stuffed after long runs of ones so that the receiver always sees transitions. When the packet ends, the block drives an end-of-packet marker, holds the idle level for one more bit time, releases the output enable and pulses `done`.

Each bit time lasts `CLKS_PER_BIT` clock cycles. A request that arrives while a packet is in flight is dropped.

Top module: `usb_token_tx`

## Requirements
- R1: While no packet is in flight, `line_oe` is 0, `line_p` is 1, `line_n` is 0, and both `busy` and `done` are 0. This also holds right after reset.
- R2: The first 16 bits sent, least significant bit first, are the sync byte 80H and then the identifier byte. The identifier byte is {~pid_type, pid_type}, so type 4'b0001 goes out as E1H.
- R3: After the identifier, the 7 address bits are sent, then the 4 endpoint bits, each field least significant bit first.
- R4: The last five data bits are the CRC. It uses generator x^5+x^2+1 and starts from 5'b11111. It is fed with the address bits and then the endpoint bits, each LSB first. Its register is sent inverted, bit 4 first.
- R5: NRZI coding: a 0 bit inverts the line level and a 1 bit keeps it. The level before the first bit is the idle level `line_p`=1.
- R6: After six consecutive 1 bits, an extra 0 bit is inserted, including after the final CRC bit. Any 0 bit, sent or stuffed, clears the run count.
- R7: Every symbol is held for exactly `CLKS_PER_BIT` cycles. The first symbol appears in the cycle after the clock edge that samples `start`, and `busy` is 1 from that cycle on.
- R8: After the last data or stuff bit, `line_p` and `line_n` are both 0 for two bit times. Then `line_p`=1 and `line_n`=0 for one bit time, with `line_oe` still 1.
- R9: In the next cycle, `line_oe` and `busy` fall and `done` is 1 for exactly one cycle.
- R10: A `start` pulse while `busy` is 1 changes nothing in the packet being sent.
- R11: Outside the end-of-packet marker, `line_n` is always the complement of `line_p`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to send a token |
| pid_type | input | 4 | Packet type nibble |
| dev_addr | input | 7 | Device address |
| endp | input | 4 | Endpoint number |
| busy | output | 1 | A packet is in flight |
| line_p | output | 1 | Positive data line |
| line_n | output | 1 | Negative data line |
| line_oe | output | 1 | Line driver enable |
| done | output | 1 | One-cycle end-of-packet strobe |

## Verification
The request fields are captured on the edge that sees `start`, and the first symbol is visible one cycle later. From there every symbol lasts `CLKS_PER_BIT` cycles, and `done` follows one cycle after the final idle bit time. The bench builds the whole expected cycle stream into a queue when it raises `start`, including any stuffed bits. On every falling clock edge it compares one queue entry with `line_oe`, `line_p`, `line_n`, `done` and `busy`, so a symbol that arrives one cycle early or late shows up as a mismatch. When the queue is empty, the same comparison holds the outputs to the idle values.

// File: rtl/usb_tkn_pkg.sv
package usb_tkn_pkg;
    localparam int FRAME_BITS = 32;
    localparam int CRC_BITS   = 5;
    localparam int FIELD_BITS = 11;
    localparam int IDX_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_DATA = 2'd1,
        PH_EOP  = 2'd2,
        PH_TAIL = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e                ph;
        logic [FRAME_BITS-1:0] frame;
        logic [IDX_W-1:0]      idx;
        logic [2:0]            ones;
        logic [1:0]            eop;
        logic                  lvl;
        logic                  oe;
        logic                  done;
    } tx_state_t;
endpackage

// File: rtl/tkn_crc5.sv
module tkn_crc5 #(
    parameter int IN_BITS = 11
) (
    input  logic [IN_BITS-1:0] data,
    output logic [4:0]         crc_inv
);
    logic [4:0] chain [0:IN_BITS];

    assign chain[0] = 5'b11111;

    for (genvar i = 0; i < IN_BITS; i++) begin : g_step
        logic fb;
        assign fb = data[i] ^ chain[i][4];
        assign chain[i+1] = {chain[i][3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
    end

    assign crc_inv = ~chain[IN_BITS];
endmodule

// File: rtl/tkn_frame.sv
module tkn_frame
    import usb_tkn_pkg::*;
(
    input  logic [3:0]            pid_type,
    input  logic [6:0]            dev_addr,
    input  logic [3:0]            endp,
    input  logic [CRC_BITS-1:0]   crc_inv,
    output logic [FRAME_BITS-1:0] frame
);
    localparam int CRC_POS = FRAME_BITS - CRC_BITS;

    assign frame[7:0]   = 8'h80;
    assign frame[15:8]  = {~pid_type, pid_type};
    assign frame[22:16] = dev_addr;
    assign frame[26:23] = endp;

    for (genvar k = 0; k < CRC_BITS; k++) begin : g_crc
        assign frame[CRC_POS + k] = crc_inv[CRC_BITS - 1 - k];
    end
endmodule

// File: rtl/tkn_bit_div.sv
module tkn_bit_div #(
    parameter int CLKS_PER_BIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear || cnt_q == LAST) cnt_d = '0;
        else                        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = !clear && (cnt_q == LAST);
endmodule

// File: rtl/usb_token_tx.sv
module usb_token_tx
    import usb_tkn_pkg::*;
#(
    parameter int CLKS_PER_BIT = 4,
    parameter int STUFF_RUN    = 6,
    parameter int EOP_BITS     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [3:0] pid_type,
    input  logic [6:0] dev_addr,
    input  logic [3:0] endp,
    output logic       busy,
    output logic       line_p,
    output logic       line_n,
    output logic       line_oe,
    output logic       done
);
    localparam logic [2:0]       RUN_MAX  = 3'(STUFF_RUN);
    localparam logic [1:0]       EOP_LAST = 2'(EOP_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(FRAME_BITS);

    tx_state_t s_d, s_q;

    logic [CRC_BITS-1:0]   crc_inv;
    logic [FRAME_BITS-1:0] frame_w;
    logic                  tick;

    tkn_crc5 #(.IN_BITS(FIELD_BITS)) u_crc (
        .data    ({endp, dev_addr}),
        .crc_inv (crc_inv)
    );

    tkn_frame u_frame (
        .pid_type (pid_type),
        .dev_addr (dev_addr),
        .endp     (endp),
        .crc_inv  (crc_inv),
        .frame    (frame_w)
    );

    tkn_bit_div #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (s_q.ph == PH_OFF),
        .tick  (tick)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.ph)
            PH_OFF: begin
                if (start) begin
                    s_d.ph    = PH_DATA;
                    s_d.frame = frame_w;
                    s_d.oe    = 1'b1;
                    s_d.idx   = IDX_W'(1);
                    if (frame_w[0]) begin
                        s_d.ones = 3'd1;
                    end else begin
                        s_d.ones = 3'd0;
                        s_d.lvl  = ~s_q.lvl;
                    end
                end
            end
            PH_DATA: begin
                if (tick) begin
                    if (s_q.ones == RUN_MAX) begin
                        s_d.ones = 3'd0;
                        s_d.lvl  = ~s_q.lvl;
                    end else if (s_q.idx < IDX_END) begin
                        s_d.idx = s_q.idx + 1'b1;
                        if (s_q.frame[s_q.idx[IDX_W-2:0]]) begin
                            s_d.ones = s_q.ones + 1'b1;
                        end else begin
                            s_d.ones = 3'd0;
                            s_d.lvl  = ~s_q.lvl;
                        end
                    end else begin
                        s_d.ph  = PH_EOP;
                        s_d.eop = 2'd0;
                    end
                end
            end
            PH_EOP: begin
                if (tick) begin
                    if (s_q.eop == EOP_LAST) begin
                        s_d.ph  = PH_TAIL;
                        s_d.lvl = 1'b1;
                    end else begin
                        s_d.eop = s_q.eop + 1'b1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    s_d.ph   = PH_OFF;
                    s_d.oe   = 1'b0;
                    s_d.lvl  = 1'b1;
                    s_d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ph    <= PH_OFF;
            s_q.lvl   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = (s_q.ph != PH_OFF);
    assign line_oe = s_q.oe;
    assign line_p  = (s_q.ph == PH_EOP) ? 1'b0 : s_q.lvl;
    assign line_n  = (s_q.ph == PH_EOP) ? 1'b0 : ~s_q.lvl;
    assign done    = s_q.done;
endmodule

// File: rtl/usb_token_tx_chk.sv
module usb_token_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic line_p,
    input logic line_n,
    input logic line_oe,
    input logic done
);
    // R11
    complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_p || line_n) |-> (line_p != line_n));

    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |-> (line_p && !line_n));

    // R8
    eop_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_p && !line_n) |-> line_oe);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!line_oe && !busy && $past(busy)));

    // R7
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && line_oe && !(!line_p && !line_n)) |=> busy);
endmodule

bind usb_token_tx usb_token_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .line_p  (line_p),
    .line_n  (line_n),
    .line_oe (line_oe),
    .done    (done)
);

// File: tb/sim_usb_token_tx.sv
module sim_usb_token_tx;
    localparam int CPB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] pid_type = '0;
    logic [6:0] dev_addr = '0;
    logic [3:0] endp = '0;
    logic       busy, line_p, line_n, line_oe, done;

    int n_run = 0;
    int n_fail = 0;

    logic [4:0] exp_q [$];
    string      tag_q [$];
    string      extra_tag = "";

    always #4 clk = ~clk;

    usb_token_tx #(.CLKS_PER_BIT(CPB)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pid_type(pid_type),
        .dev_addr(dev_addr), .endp(endp), .busy(busy), .line_p(line_p),
        .line_n(line_n), .line_oe(line_oe), .done(done)
    );

    function automatic logic [4:0] ref_crc(input logic [6:0] a, input logic [3:0] e);
        logic [10:0] m;
        logic [4:0]  r;
        m = {e, a};
        r = 5'b11111;
        for (int i = 0; i < 11; i++) begin
            logic top;
            top = r[4] ^ m[i];
            r   = {r[3:0], 1'b0};
            if (top) r = r ^ 5'b00101;
        end
        return ~r;
    endfunction

    task automatic push_sym(input logic [4:0] v, input string t, input int n);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(v);
            tag_q.push_back(t);
        end
    endtask

    // Builds the cycle stream {oe, p, n, done, busy} for one token.
    task automatic build_expect(input logic [3:0] t, input logic [6:0] a, input logic [3:0] e);
        int    bits [$];
        string btag [$];
        int    ones;
        logic  lvl;
        logic [7:0] pid;
        logic [4:0] c;
        pid = {~t, t};
        c = ref_crc(a, e);
        for (int i = 0; i < 8; i++) begin bits.push_back((8'h80 >> i) & 1); btag.push_back("R2 R5 R7"); end
        for (int i = 0; i < 8; i++) begin bits.push_back(pid[i]); btag.push_back("R2 R5 R7"); end
        for (int i = 0; i < 7; i++) begin bits.push_back(a[i]); btag.push_back("R3 R5 R11"); end
        for (int i = 0; i < 4; i++) begin bits.push_back(e[i]); btag.push_back("R3 R5 R11"); end
        for (int i = 4; i >= 0; i--) begin bits.push_back(c[i]); btag.push_back("R4 R5"); end
        ones = 0;
        lvl = 1'b1;
        for (int i = 0; i < bits.size(); i++) begin
            if (bits[i] == 0) begin lvl = ~lvl; ones = 0; end
            else ones++;
            push_sym({1'b1, lvl, ~lvl, 1'b0, 1'b1}, {btag[i], extra_tag}, CPB);
            if (ones == 6) begin
                lvl = ~lvl;
                ones = 0;
                push_sym({1'b1, lvl, ~lvl, 1'b0, 1'b1}, {"R6", extra_tag}, CPB);
            end
        end
        push_sym(5'b10001, {"R8", extra_tag}, 2 * CPB);
        push_sym(5'b11001, {"R8", extra_tag}, CPB);
        push_sym(5'b01010, {"R9", extra_tag}, 1);
    endtask

    task automatic cycle_check();
        logic [4:0] act, expv;
        string t;
        @(negedge clk);
        act = {line_oe, line_p, line_n, done, busy};
        if (exp_q.size() > 0) begin
            expv = exp_q.pop_front();
            t = tag_q.pop_front();
        end else begin
            expv = 5'b01000;
            t = "R1";
        end
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s at %0t: {oe,p,n,done,busy} actual %b expected %b", t, $time, act, expv);
        end
    endtask

    task automatic send(input logic [3:0] t, input logic [6:0] a, input logic [3:0] e);
        pid_type = t; dev_addr = a; endp = e; start = 1'b1;
        build_expect(t, a, e);
        cycle_check();
        start = 1'b0;
        pid_type = ~t; dev_addr = ~a; endp = ~e;
        while (exp_q.size() > 0) cycle_check();
        repeat (3) cycle_check();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected complete");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) cycle_check();            // R1 under reset
        @(negedge clk); rst_n = 1'b1;
        repeat (3) cycle_check();            // R1 after reset
        send(4'b0001, 7'h00, 4'h0);          // OUT token: E1H
        send(4'b1001, 7'h7F, 4'hF);          // IN token, long runs of ones (R6)
        send(4'b1101, 7'h15, 4'h3);          // SETUP token
        send(4'b0101, 7'h3A, 4'hA);          // start-of-frame type
        send(4'b1111, 7'h7E, 4'h7);
        // R10: second start while busy must not disturb the packet
        extra_tag = " R10";
        pid_type = 4'b0001; dev_addr = 7'h55; endp = 4'h5; start = 1'b1;
        build_expect(4'b0001, 7'h55, 4'h5);
        cycle_check();
        start = 1'b0;
        repeat (20) cycle_check();
        pid_type = 4'b1001; dev_addr = 7'h7F; endp = 4'hF; start = 1'b1;
        cycle_check();
        start = 1'b0;
        while (exp_q.size() > 0) cycle_check();
        extra_tag = "";
        repeat (4) cycle_check();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule